// File: doc/BRIEF.md
# Touch Pen Interrupt Controller

This block generates the active-low pen-touch interrupt request of a touch-screen digitizer. A host monitors the request line. When a pen or finger touches the screen, the line is pulled low. The host then writes a control word over the serial port to start a conversion. The block watches the serial clock, chip-select and data-in lines for the start bit of each control word.

The start bit disarms the interrupt. If the line was already being pulled low, it is held low until the fourth falling serial-clock edge after the start bit. It is then released, whatever the touch state. The two power-down bits at the tail of the word decide whether the interrupt re-arms. That decision takes effect only when the converter signals end of conversion.

The output models an open-drain pin: `irq_pull_low` = 1 means the pad pulls the line low. All serial inputs and the touch detect pass through a two-flop synchronizer into the system clock domain.

Top module: `touch_pen_irq`

## Requirements
- R1: After reset the interrupt is armed: with `touch_in` = 1 the block drives `irq_pull_low` = 1 without any control word having been written.
- R2: While armed and not holding, `irq_pull_low` follows `touch_in`: 1 while touched, 0 while not touched.
- R3: A start bit is the first 1 sampled on a rising `ser_clk` edge while `ser_cs_n` = 0 and no word is in progress. It disarms the interrupt, and later touches leave `irq_pull_low` at 0.
- R4: If `irq_pull_low` was 1 when the start bit arrived, it stays 1 through the first three falling `ser_clk` edges after that bit. It returns to 0 on the fourth falling edge.
- R5: A control word is 8 bits, sent MSB first, with the start bit as the first bit. The last two bits form the power-down field, upper bit first. A lower bit of 0 requests re-arming; a lower bit of 1 requests no re-arming.
- R6: A re-arm request takes effect only on a `conv_done` pulse. Between loading the word and that pulse, touches leave `irq_pull_low` at 0.
- R7: A new start bit that arrives before `conv_done` cancels the pending request from the previous word. That `conv_done` then leaves the interrupt disarmed.
- R8: Raising `ser_cs_n` aborts a word in progress and releases a held output at once. While `ser_cs_n` = 1, `ser_clk` and `ser_din` activity is ignored.
- R9: When the loaded lower power-down bit is 1, the interrupt stays disarmed after `conv_done`, and touches leave `irq_pull_low` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_clk | input | 1 | Serial port clock, sampled in the system domain |
| ser_cs_n | input | 1 | Serial chip-select, active low |
| ser_din | input | 1 | Serial data-in carrying the control words |
| conv_done | input | 1 | One-cycle end-of-conversion pulse, synchronous to `clk` |
| touch_in | input | 1 | Touch detect, 1 while the screen is pressed (asynchronous) |
| irq_pull_low | output | 1 | Open-drain enable: 1 pulls the interrupt line low |

## Verification
The bench builds the block with its defaults: two synchronizer stages, 8-bit words and release on the fourth falling edge. Each serial half-period lasts ten system clocks. At that spacing every edge passes fully through the synchronizer before the next edge arrives. This lets the bench sample the output after each individual falling edge. It can therefore pin down exactly which edge ends the hold. The bench sweeps all four power-down codes, with the touch both absent and present when the word starts. It also covers a word overlapped with the next start bit, a chip-select abort in the middle of a word, and clocking while deselected.

// File: rtl/tpi_pkg.sv
package tpi_pkg;

  localparam int unsigned DEF_SYNC_STAGES   = 2;
  localparam int unsigned DEF_WORD_BITS     = 8;
  localparam int unsigned DEF_RELEASE_FALLS = 4;

  // Lower power-down bit clear means the pen interrupt is wanted again.
  function automatic logic pd_rearms(input logic pd_lo);
    return ~pd_lo;
  endfunction

endpackage

// File: rtl/tpi_sync.sv
module tpi_sync #(
  parameter int unsigned          W       = 1,
  parameter int unsigned          STAGES  = 2,
  parameter logic        [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] src;
    if (g == 0) begin : g_first
      assign src = d;
    end else begin : g_rest
      assign src = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= RST_VAL;
      else        stage_q[g] <= src;
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/tpi_ctrl_rx.sv
module tpi_ctrl_rx #(
  parameter int unsigned WORD_BITS     = 8,
  parameter int unsigned RELEASE_FALLS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_s,
  input  logic       cs_act,
  input  logic       din_s,
  output logic       start_p,
  output logic       pd_load_p,
  output logic [1:0] pd_val,
  output logic       release_p
);

  localparam int unsigned BCW = $clog2(WORD_BITS + 1);
  localparam int unsigned FCW = $clog2(RELEASE_FALLS + 1);

  logic           sclk_prev_q;
  logic           active_q,   active_d;
  logic [BCW-1:0] bit_cnt_q,  bit_cnt_d;
  logic           prev_bit_q, prev_bit_d;
  logic           fall_run_q, fall_run_d;
  logic [FCW-1:0] fall_cnt_q, fall_cnt_d;
  logic           start_q,    start_d;
  logic           load_q,     load_d;
  logic [1:0]     pd_q,       pd_d;
  logic           rel_q,      rel_d;
  logic           rise, fall;

  assign rise = sclk_s & ~sclk_prev_q;
  assign fall = ~sclk_s & sclk_prev_q;

  always_comb begin
    active_d   = active_q;
    bit_cnt_d  = bit_cnt_q;
    prev_bit_d = prev_bit_q;
    fall_run_d = fall_run_q;
    fall_cnt_d = fall_cnt_q;
    pd_d       = pd_q;
    start_d    = 1'b0;
    load_d     = 1'b0;
    rel_d      = 1'b0;
    if (!cs_act) begin
      active_d   = 1'b0;
      bit_cnt_d  = '0;
      fall_run_d = 1'b0;
      fall_cnt_d = '0;
    end else begin
      if (rise) begin
        if (!active_q) begin
          if (din_s) begin
            active_d   = 1'b1;
            bit_cnt_d  = BCW'(1);
            prev_bit_d = din_s;
            start_d    = 1'b1;
            fall_run_d = 1'b1;
            fall_cnt_d = '0;
          end
        end else begin
          prev_bit_d = din_s;
          bit_cnt_d  = bit_cnt_q + 1'b1;
          if (bit_cnt_q == BCW'(WORD_BITS - 1)) begin
            active_d  = 1'b0;
            bit_cnt_d = '0;
            load_d    = 1'b1;
            pd_d      = {prev_bit_q, din_s};
          end
        end
      end
      if (fall && fall_run_q) begin
        fall_cnt_d = fall_cnt_q + 1'b1;
        if (fall_cnt_q == FCW'(RELEASE_FALLS - 1)) begin
          fall_run_d = 1'b0;
          fall_cnt_d = '0;
          rel_d      = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      active_q    <= 1'b0;
      bit_cnt_q   <= '0;
      prev_bit_q  <= 1'b0;
      fall_run_q  <= 1'b0;
      fall_cnt_q  <= '0;
      start_q     <= 1'b0;
      load_q      <= 1'b0;
      pd_q        <= 2'b00;
      rel_q       <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_s;
      active_q    <= active_d;
      bit_cnt_q   <= bit_cnt_d;
      prev_bit_q  <= prev_bit_d;
      fall_run_q  <= fall_run_d;
      fall_cnt_q  <= fall_cnt_d;
      start_q     <= start_d;
      load_q      <= load_d;
      rel_q       <= rel_d;
      if (load_d) pd_q <= pd_d;
    end
  end

  assign start_p   = start_q;
  assign pd_load_p = load_q;
  assign pd_val    = pd_q;
  assign release_p = rel_q;

endmodule

// File: rtl/tpi_arm_ctrl.sv
module tpi_arm_ctrl
  import tpi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_p,
  input  logic pd_load_p,
  input  logic pd_lo,
  input  logic conv_done,
  input  logic release_p,
  input  logic abort,
  input  logic touch_s,
  output logic drive_low,
  output logic armed,
  output logic hold
);

  logic armed_q, armed_d;
  logic pend_v_q, pend_v_d;
  logic pend_en_q, pend_en_d;
  logic hold_q, hold_d;

  always_comb begin
    armed_d   = armed_q;
    pend_v_d  = pend_v_q;
    pend_en_d = pend_en_q;
    hold_d    = hold_q;
    if (start_p) begin
      armed_d  = 1'b0;
      pend_v_d = 1'b0;
    end else if (pd_load_p) begin
      pend_v_d  = 1'b1;
      pend_en_d = pd_rearms(pd_lo);
    end else if (conv_done && pend_v_q) begin
      armed_d  = pend_en_q;
      pend_v_d = 1'b0;
    end
    if (release_p || abort) hold_d = 1'b0;
    else if (start_p)       hold_d = armed_q & touch_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b1;
      pend_v_q  <= 1'b0;
      pend_en_q <= 1'b0;
      hold_q    <= 1'b0;
    end else begin
      armed_q   <= armed_d;
      pend_v_q  <= pend_v_d;
      pend_en_q <= pend_en_d;
      hold_q    <= hold_d;
    end
  end

  assign drive_low = hold_q | (armed_q & touch_s);
  assign armed     = armed_q;
  assign hold      = hold_q;

endmodule

// File: rtl/touch_pen_irq.sv
module touch_pen_irq
  import tpi_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = DEF_SYNC_STAGES,
  parameter int unsigned WORD_BITS     = DEF_WORD_BITS,
  parameter int unsigned RELEASE_FALLS = DEF_RELEASE_FALLS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_cs_n,
  input  logic ser_din,
  input  logic conv_done,
  input  logic touch_in,
  output logic irq_pull_low
);

  logic [1:0] rst_pipe_q;
  logic       rst_q_n;
  logic [2:0] ser_s;
  logic       touch_s;
  logic       abort_s;
  logic       start_p, pd_load_p, release_p;
  logic [1:0] pd_val;
  logic       arm_state, hold_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q_n = rst_pipe_q[1];

  tpi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_ser_sync (
    .clk(clk), .rst_n(rst_q_n),
    .d({ser_clk, ser_cs_n, ser_din}), .q(ser_s)
  );

  tpi_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_touch_sync (
    .clk(clk), .rst_n(rst_q_n), .d(touch_in), .q(touch_s)
  );

  assign abort_s = ser_s[1];

  tpi_ctrl_rx #(.WORD_BITS(WORD_BITS), .RELEASE_FALLS(RELEASE_FALLS)) u_rx (
    .clk(clk), .rst_n(rst_q_n),
    .sclk_s(ser_s[2]), .cs_act(~ser_s[1]), .din_s(ser_s[0]),
    .start_p(start_p), .pd_load_p(pd_load_p), .pd_val(pd_val),
    .release_p(release_p)
  );

  tpi_arm_ctrl u_arm (
    .clk(clk), .rst_n(rst_q_n),
    .start_p(start_p), .pd_load_p(pd_load_p), .pd_lo(pd_val[0]),
    .conv_done(conv_done), .release_p(release_p), .abort(abort_s),
    .touch_s(touch_s), .drive_low(irq_pull_low),
    .armed(arm_state), .hold(hold_state)
  );

endmodule

// File: rtl/tpi_checker.sv
module tpi_checker (
  input logic clk,
  input logic rst_q_n,
  input logic start_p,
  input logic release_p,
  input logic abort_s,
  input logic conv_done,
  input logic arm_state,
  input logic hold_state,
  input logic irq_pull_low
);

  // R3: a start bit leaves the interrupt disarmed
  a_r3_start_disarms: assert property (@(posedge clk) disable iff (!rst_q_n)
    start_p |=> !arm_state);

  // R2 / R3: with nothing armed or held the line idles released
  a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!arm_state && !hold_state) |-> !irq_pull_low);

  // R6: re-arming happens only right after an end-of-conversion pulse
  a_r6_rearm_on_done: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(arm_state) |-> $past(conv_done));

  // R4: a hold begins only at a start bit
  a_r4_hold_from_start: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(hold_state) |-> $past(start_p));

  // R4 / R8: a hold ends only on the release edge or an abort
  a_r4_hold_end: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(hold_state) |-> $past(release_p || abort_s));

  // R8: deselection clears any hold
  a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_q_n)
    abort_s |=> !hold_state);

endmodule

bind touch_pen_irq tpi_checker u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .start_p(start_p), .release_p(release_p),
  .abort_s(abort_s), .conv_done(conv_done), .arm_state(arm_state),
  .hold_state(hold_state), .irq_pull_low(irq_pull_low)
);

// File: tb/touch_pen_irq_tb.sv
module touch_pen_irq_tb;

  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n, ser_clk, ser_cs_n, ser_din, conv_done, touch_in;
  logic irq_pull_low;
  int   checks = 0;
  int   errors = 0;

  always #4 clk = ~clk;

  touch_pen_irq u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_cs_n(ser_cs_n),
    .ser_din(ser_din), .conv_done(conv_done), .touch_in(touch_in),
    .irq_pull_low(irq_pull_low)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic exp);
    checks++;
    if (irq_pull_low !== exp) begin
      errors++;
      $display("FAIL %s: irq_pull_low=%0b expected %0b", req, irq_pull_low, exp);
    end
  endtask

  // one serial bit: data set, low half, rising edge, high half, falling edge
  task automatic bit_out(input logic b);
    ser_din = b;
    wait_n(H);
    ser_clk = 1'b1;
    wait_n(H);
    ser_clk = 1'b0;
  endtask

  function automatic logic [7:0] mk_word(input logic [1:0] pd);
    return {1'b1, 5'b10101, pd};
  endfunction

  task automatic send_word(input logic [7:0] w);
    ser_cs_n = 1'b0;
    wait_n(H);
    for (int i = 7; i >= 0; i--) bit_out(w[i]);
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    wait_n(H);
    ser_cs_n = 1'b1;
    wait_n(H);
  endtask

  task automatic pulse_done();
    conv_done = 1'b1;
    wait_n(1);
    conv_done = 1'b0;
    wait_n(8);
  endtask

  task automatic set_touch(input logic t);
    touch_in = t;
    wait_n(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ser_clk = 1'b0; ser_cs_n = 1'b1; ser_din = 1'b0;
    conv_done = 1'b0; touch_in = 1'b0;
    wait_n(5);
    chk("R1 reset state", 1'b0);
    rst_n = 1'b1;
    wait_n(6);

    // R1 / R2: armed by default, output follows touch
    set_touch(1'b1); chk("R1 armed after reset", 1'b1);
    set_touch(1'b0); chk("R2 untouched releases", 1'b0);
    set_touch(1'b1); chk("R2 touched pulls low", 1'b1);

    // R4 / R3: hold through three falls, release on the fourth
    ser_cs_n = 1'b0; wait_n(H);
    bit_out(1'b1); wait_n(8); chk("R4 held after fall 1", 1'b1);
    bit_out(1'b0); wait_n(8); chk("R4 held after fall 2", 1'b1);
    bit_out(1'b1); wait_n(8); chk("R4 held after fall 3", 1'b1);
    bit_out(1'b0); wait_n(8); chk("R4 released on fall 4 (R3 touch ignored)", 1'b0);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    wait_n(H); ser_cs_n = 1'b1; wait_n(H);
    chk("R6 no re-arm before conv_done", 1'b0);
    pulse_done();
    chk("R6 re-armed by conv_done (pd=10)", 1'b1);
    set_touch(1'b0);

    // R5 / R9: sweep all power-down codes
    for (int pd = 0; pd < 4; pd++) begin
      send_word(mk_word(2'(pd)));
      set_touch(1'b1);
      chk("R6 ignored before done in sweep", 1'b0);
      pulse_done();
      chk((pd % 2 == 0) ? "R5 lower pd bit 0 re-arms" : "R9 lower pd bit 1 stays off",
          (pd % 2 == 0) ? 1'b1 : 1'b0);
      set_touch(1'b0);
    end

    // R3: not touched at start, touch during word is ignored
    send_word(mk_word(2'b00)); pulse_done();
    ser_cs_n = 1'b0; wait_n(H);
    bit_out(1'b1); bit_out(1'b0);
    set_touch(1'b1); chk("R3 touch after start ignored", 1'b0);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
    bit_out(1'b0); bit_out(1'b0);
    wait_n(H); ser_cs_n = 1'b1; wait_n(H);
    set_touch(1'b0);

    // R7: next start before conv_done cancels pending re-arm
    send_word(mk_word(2'b00));
    ser_cs_n = 1'b0; wait_n(H);
    bit_out(1'b1);
    wait_n(4); pulse_done();
    for (int i = 0; i < 5; i++) bit_out(1'b0);
    bit_out(1'b1); bit_out(1'b0);
    wait_n(H); ser_cs_n = 1'b1; wait_n(H);
    set_touch(1'b1); chk("R7 overlapped start keeps disarmed", 1'b0);
    pulse_done();
    chk("R7 later conv_done applies second word", 1'b1);

    // R8: abort mid-word releases hold
    ser_cs_n = 1'b0; wait_n(H);
    bit_out(1'b1); bit_out(1'b0); wait_n(8);
    chk("R8 held before abort", 1'b1);
    ser_cs_n = 1'b1; wait_n(8);
    chk("R8 abort releases at once", 1'b0);
    pulse_done();
    chk("R8 aborted word loads nothing", 1'b0);
    set_touch(1'b0);

    // R8: clocking while deselected is ignored
    send_word(mk_word(2'b10)); pulse_done();
    set_touch(1'b1);
    for (int i = 0; i < 10; i++) bit_out(1'b1);
    wait_n(8);
    chk("R8 deselected clocks ignored", 1'b1);
    set_touch(1'b0); chk("R2 released after deselected clocks", 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule